// File: doc/BRIEF.md
# Register-Mapped Serial Transceiver with Error Flags

This block is a full-duplex asynchronous serial port that software reaches through a small register interface. It has one transmit holding register, one receive data register and a status register. Character length, parity mode and the clock divider that sets the baud rate are fixed at elaboration. There is no queueing: one received character waits for software, and one outgoing character can wait behind the one being shifted out.

The receiver samples the line at sixteen times the bit rate and takes each bit at its middle. A falling edge counts as a start bit only if the line is still low half a bit later. A received character can end in three kinds of error, and each is handled differently. A bad parity bit still stores the character. A low stop bit throws the character away. A character that arrives while the previous one is unread is dropped and reported as an overrun. The error flags are sticky until software reads the status register. A single-cycle interrupt pulse marks each of these events: a received character, the holding register emptying, and any error.

Register select values: 0 is receive data, 1 is transmit data, 2 is status, 3 reads as zero. Status fields: bit 0 receive data valid, bit 3 transmit holding register full, bit 5 overrun, bit 6 frame error, bit 7 parity error. Every other bit is 0.

Top module: `sio_uart`

## Requirements
- R1: After reset the status reads 0x00, receive data reads 0x00, txd is high and irq is low.
- R2: Each transmitted frame is one low start bit, then DATA_BITS data bits LSB first, then a parity bit when parity is enabled, then one high stop bit. With even parity the data and parity bits together hold an even number of ones. With odd parity they hold an odd number. Each bit lasts 16 × CLKS_PER_TICK clocks.
- R3: A correctly framed received character sets status bit 0. Reading register 0 returns the character zero-extended and clears bit 0 on the following edge. Reading again with nothing new returns the same data.
- R4: A received character with the wrong parity bit is stored and sets bit 0 together with the sticky parity flag, status bit 7.
- R5: A character whose stop bit samples low sets the sticky frame flag, status bit 6. The character is not stored, and bit 0 and the receive data are left unchanged. The receiver accepts no new start bit until the line has returned high.
- R6: A character that completes while bit 0 is set and register 0 is not being read sets the sticky overrun flag, status bit 5. The new character is dropped and the stored data is kept.
- R7: Status bits 7, 6 and 5 stay set until the status register is read, and are clear on the next read unless a new error occurred.
- R8: Status bit 3 is set while a character waits in the transmit holding register. A write while bit 3 is set replaces the waiting character, so the earlier one is never sent.
- R9: Writes to register 0 change nothing. Reads of register 1 and register 3 return 0.
- R10: irq pulses for one cycle when a character is stored, when the holding register passes its character to the shifter, and when any error is detected.
- R11: A low pulse on rxd that ends before the mid-bit check is ignored. No character, flag or irq results from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 receive, 1 transmit, 2 status |
| rd_en | input | 1 | Read strobe; side effects take place at the clock edge |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from reg_sel while rd_en is high |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Single-cycle event pulse |

## Verification
A received character is registered two synchroniser cycles plus at most one tick after the middle of its stop bit. The bench drives the complete stop bit before it reads, which leaves half a bit of margin. Read data is valid in the same cycle as the strobe, and the clearing side effect of a read appears one edge later, so the bench samples rd_data one time unit after driving the strobe at the falling edge. Transmitted bits are recovered by a bench decoder that samples txd in the middle of each bit, measured from the start edge it detects. irq pulses are counted on falling edges and compared per scenario against the number of events the requirements predict.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_ODD  = 2'd1,
    PAR_EVEN = 2'd2
  } par_mode_e;

  localparam int unsigned REG_W = 8;

  // parity bit over the low n bits of d for the given mode
  function automatic logic par_bit(input logic [7:0] d, input int unsigned n,
                                   input par_mode_e m);
    logic x;
    x = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < n) x = x ^ d[i];
    end
    return (m == PAR_ODD) ? ~x : x;
  endfunction
endpackage

// File: rtl/sio_tick_gen.sv
module sio_tick_gen #(
  parameter int unsigned CLKS_PER_TICK = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_TICK - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8,
  parameter par_mode_e   PARITY    = PAR_EVEN
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 load,
  input  logic [DATA_BITS-1:0] data,
  output logic                 ready,
  output logic                 txd
);
  localparam int unsigned PB = (PARITY == PAR_NONE) ? 0 : 1;
  localparam int unsigned FB = DATA_BITS + PB + 2;
  localparam int unsigned IW = $clog2(FB + 1);

  logic          busy_q, busy_d;
  logic [FB-1:0] sh_q, sh_d, frame;
  logic [3:0]    tcnt_q, tcnt_d;
  logic [IW-1:0] bidx_q, bidx_d;
  logic [7:0]    data8;

  always_comb begin
    data8 = '0;
    data8[DATA_BITS-1:0] = data;
    frame = '1;
    frame[0] = 1'b0;
    frame[DATA_BITS:1] = data;
    if (PB != 0) frame[DATA_BITS+1] = par_bit(data8, DATA_BITS, PARITY);
  end

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    tcnt_d = tcnt_q;
    bidx_d = bidx_q;
    if (!busy_q) begin
      if (load) begin
        busy_d = 1'b1;
        sh_d   = frame;
        tcnt_d = '0;
        bidx_d = '0;
      end
    end else if (tick) begin
      tcnt_d = tcnt_q + 1'b1;
      if (tcnt_q == 4'd15) begin
        sh_d = {1'b1, sh_q[FB-1:1]};
        if (bidx_q == IW'(FB - 1)) busy_d = 1'b0;
        else                       bidx_d = bidx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      tcnt_q <= '0;
      bidx_q <= '0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      tcnt_q <= tcnt_d;
      bidx_q <= bidx_d;
    end
  end

  assign ready = !busy_q;
  assign txd   = busy_q ? sh_q[0] : 1'b1;

  // R2: the last bit slot of every frame drives a high stop bit
  a_r2_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && bidx_q == IW'(FB - 1)) |-> txd);
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8,
  parameter par_mode_e   PARITY    = PAR_EVEN
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rxd,
  output logic                 done,
  output logic [DATA_BITS-1:0] data,
  output logic                 perr,
  output logic                 ferr
);
  localparam int unsigned PB = (PARITY == PAR_NONE) ? 0 : 1;
  localparam int unsigned NS = DATA_BITS + PB + 1;
  localparam int unsigned IW = $clog2(NS + 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_RUN, RX_WAIT_HI} rx_st_e;

  rx_st_e        st_q, st_d;
  logic [3:0]    tcnt_q, tcnt_d;
  logic [IW-1:0] bidx_q, bidx_d;
  logic [NS-1:0] sh_q, sh_d;
  logic          s1_q, s2_q;
  logic [7:0]    data8;

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    bidx_d = bidx_q;
    sh_d   = sh_q;
    done   = 1'b0;
    unique case (st_q)
      RX_IDLE: if (tick && !s2_q) begin
        st_d   = RX_START;
        tcnt_d = '0;
      end
      RX_START: if (tick) begin
        if (tcnt_q == 4'd7) begin
          tcnt_d = '0;
          bidx_d = '0;
          st_d   = s2_q ? RX_IDLE : RX_RUN;
        end else begin
          tcnt_d = tcnt_q + 1'b1;
        end
      end
      RX_RUN: if (tick) begin
        tcnt_d = tcnt_q + 1'b1;
        if (tcnt_q == 4'd15) begin
          sh_d = {s2_q, sh_q[NS-1:1]};
          if (bidx_q == IW'(NS - 1)) begin
            done = 1'b1;
            st_d = s2_q ? RX_IDLE : RX_WAIT_HI;
          end else begin
            bidx_d = bidx_q + 1'b1;
          end
        end
      end
      RX_WAIT_HI: if (s2_q) st_d = RX_IDLE;
      default: st_d = RX_IDLE;
    endcase
  end

  always_comb begin
    data  = sh_d[DATA_BITS-1:0];
    data8 = '0;
    data8[DATA_BITS-1:0] = data;
    ferr  = !sh_d[NS-1];
    perr  = (PB != 0) ? (sh_d[DATA_BITS] != par_bit(data8, DATA_BITS, PARITY)) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      tcnt_q <= '0;
      bidx_q <= '0;
      sh_q   <= '0;
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
    end else begin
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
      bidx_q <= bidx_d;
      sh_q   <= sh_d;
      s1_q   <= rxd;
      s2_q   <= s1_q;
    end
  end

  // R11: a frame is entered only when the line was low at the mid-start check
  a_r11_start_confirmed: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_RUN && $past(st_q) == RX_START) |-> !$past(s2_q));

  // R5: after a low stop bit no start is accepted before the line is high again
  a_r5_wait_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_WAIT_HI && !s2_q) |=> (st_q == RX_WAIT_HI));
endmodule

// File: rtl/sio_uart.sv
module sio_uart
  import sio_pkg::*;
#(
  parameter int unsigned DATA_BITS     = 8,
  parameter par_mode_e   PARITY        = PAR_EVEN,
  parameter int unsigned CLKS_PER_TICK = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_sel,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       rxd,
  output logic       txd,
  output logic       irq
);
  localparam logic [1:0] SEL_RX   = 2'd0;
  localparam logic [1:0] SEL_TX   = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;

  logic                 tick;
  logic                 rx_done, rx_perr, rx_ferr;
  logic [DATA_BITS-1:0] rx_char;
  logic                 tx_ready, tx_load;

  logic [DATA_BITS-1:0] rx_data_q, rx_data_d;
  logic                 rx_valid_q, rx_valid_d;
  logic                 perr_q, perr_d, ferr_q, ferr_d, ovr_q, ovr_d;
  logic [DATA_BITS-1:0] hold_q, hold_d;
  logic                 hold_full_q, hold_full_d;
  logic                 irq_q, irq_d;

  logic rxd_rd, st_rd, tx_wr, store, ovr_ev, ferr_ev, perr_ev;

  sio_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  sio_rx #(.DATA_BITS(DATA_BITS), .PARITY(PARITY)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .done(rx_done), .data(rx_char), .perr(rx_perr), .ferr(rx_ferr)
  );

  sio_tx #(.DATA_BITS(DATA_BITS), .PARITY(PARITY)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(tx_load),
    .data(hold_q), .ready(tx_ready), .txd(txd)
  );

  always_comb begin
    rxd_rd  = rd_en && (reg_sel == SEL_RX);
    st_rd   = rd_en && (reg_sel == SEL_STAT);
    tx_wr   = wr_en && (reg_sel == SEL_TX);
    ferr_ev = rx_done && rx_ferr;
    store   = rx_done && !rx_ferr && (!rx_valid_q || rxd_rd);
    ovr_ev  = rx_done && !rx_ferr && rx_valid_q && !rxd_rd;
    perr_ev = store && rx_perr;
    tx_load = hold_full_q && tx_ready;
  end

  always_comb begin
    rx_data_d   = store ? rx_char : rx_data_q;
    rx_valid_d  = store ? 1'b1 : (rxd_rd ? 1'b0 : rx_valid_q);
    perr_d      = perr_ev | (perr_q & ~st_rd);
    ferr_d      = ferr_ev | (ferr_q & ~st_rd);
    ovr_d       = ovr_ev  | (ovr_q  & ~st_rd);
    hold_d      = tx_wr ? wr_data[DATA_BITS-1:0] : hold_q;
    hold_full_d = tx_wr ? 1'b1 : (tx_load ? 1'b0 : hold_full_q);
    irq_d       = store | ovr_ev | ferr_ev | (hold_full_q & ~hold_full_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data_q   <= '0;
      rx_valid_q  <= 1'b0;
      perr_q      <= 1'b0;
      ferr_q      <= 1'b0;
      ovr_q       <= 1'b0;
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      rx_data_q   <= rx_data_d;
      rx_valid_q  <= rx_valid_d;
      perr_q      <= perr_d;
      ferr_q      <= ferr_d;
      ovr_q       <= ovr_d;
      hold_q      <= hold_d;
      hold_full_q <= hold_full_d;
      irq_q       <= irq_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      unique case (reg_sel)
        SEL_RX:   rd_data[DATA_BITS-1:0] = rx_data_q;
        SEL_STAT: rd_data = {perr_q, ferr_q, ovr_q, 1'b0, hold_full_q, 2'b00, rx_valid_q};
        default:  rd_data = '0;
      endcase
    end
  end

  assign irq = irq_q;

  // R7: a sticky flag survives every cycle without a status read
  a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_q && !st_rd) |=> perr_q);

  // R5: a low stop bit leaves the stored character untouched
  a_r5_frame_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_ferr) |=> $stable(rx_data_q));

  // R6: an unread character is kept and the overrun flag rises
  a_r6_overrun_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_ferr && rx_valid_q && !rxd_rd) |=> ($stable(rx_data_q) && ovr_q));

  // R3: reading receive data with nothing arriving clears the valid bit
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rxd_rd && !rx_done) |=> !rx_valid_q);

  // R10: the interrupt is a single-cycle pulse unless a fresh event follows
  a_r10_no_spurious_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_done && !hold_full_q) |=> !irq_q);
endmodule

// File: tb/sio_uart_tb.sv
module sio_uart_tb;
  localparam int DB  = 8;
  localparam int CPT = 4;
  localparam int BIT = 16 * CPT;
  localparam int FB  = DB + 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] reg_sel;
  logic       rd_en, wr_en;
  logic [7:0] wr_data, rd_data;
  logic       rxd, txd, irq;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  int dec_n = 0;
  logic [7:0] dec_data [0:63];
  logic       dec_par  [0:63];
  logic       dec_stop [0:63];

  always #4 clk = ~clk;

  sio_uart u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .rxd(rxd), .txd(txd), .irq(irq)
  );

  function automatic logic even_par(input logic [7:0] d);
    return ^d;
  endfunction

  function automatic logic [7:0] stat_val(input logic pe, input logic fe, input logic ov,
                                          input logic tf, input logic rv);
    return {pe, fe, ov, 1'b0, tf, 2'b00, rv};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk);
    reg_sel = s; rd_en = 1'b1;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic bus_wr(input logic [1:0] s, input logic [7:0] v);
    @(negedge clk);
    reg_sel = s; wr_data = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    logic [FB-1:0] f;
    f = {~bad_stop, even_par(d) ^ bad_par, d, 1'b0};
    for (int i = 0; i < FB; i++) begin
      @(negedge clk) rxd = f[i];
      repeat (BIT - 1) @(negedge clk);
    end
    @(negedge clk) rxd = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  // irq pulse counter
  always @(negedge clk) if (rst_n === 1'b1 && irq === 1'b1) irq_cnt++;

  // transmit line decoder: samples each bit in its middle
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && txd === 1'b0) begin
        logic [FB-2:0] b;
        repeat (BIT / 2) @(negedge clk);
        if (txd === 1'b0) begin
          for (int i = 0; i < FB - 1; i++) begin
            repeat (BIT) @(negedge clk);
            b[i] = txd;
          end
          if (dec_n < 64) begin
            dec_data[dec_n] = b[7:0];
            dec_par[dec_n]  = b[8];
            dec_stop[dec_n] = b[9];
          end
          dec_n++;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=0x1 expected=0x0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v, r, t;
    int irq0, n0;
    void'($urandom(32'd1234));
    rst_n = 1'b0; reg_sel = '0; rd_en = 1'b0; wr_en = 1'b0; wr_data = '0; rxd = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    bus_rd(2'd2, v); chk("R1 status", v, 8'h00);
    bus_rd(2'd0, v); chk("R1 rx data", v, 8'h00);
    chk("R1 txd", txd, 1);
    chk("R1 irq", irq_cnt, 0);

    // R3 receive, read, reread; R10 one pulse
    irq0 = irq_cnt;
    send_rx(8'h5A, 1'b0, 1'b0);
    bus_rd(2'd2, v); chk("R3 valid", v, stat_val(0,0,0,0,1));
    bus_rd(2'd0, v); chk("R3 data", v, 8'h5A);
    bus_rd(2'd2, v); chk("R3 valid cleared", v, 8'h00);
    bus_rd(2'd0, v); chk("R3 reread", v, 8'h5A);
    chk("R10 rx irq", irq_cnt - irq0, 1);

    // R9 ignored write and zero reads
    bus_wr(2'd0, 8'hFF);
    bus_rd(2'd0, v); chk("R9 rx write ignored", v, 8'h5A);
    bus_rd(2'd2, v); chk("R9 status after rx write", v, 8'h00);
    bus_rd(2'd1, v); chk("R9 tx reads zero", v, 8'h00);
    bus_rd(2'd3, v); chk("R9 reserved reads zero", v, 8'h00);

    // R4 parity error keeps character; R7 clear on read
    irq0 = irq_cnt;
    send_rx(8'h33, 1'b1, 1'b0);
    bus_rd(2'd2, v); chk("R4 parity flag", v, stat_val(1,0,0,0,1));
    bus_rd(2'd2, v); chk("R7 parity cleared", v, stat_val(0,0,0,0,1));
    bus_rd(2'd0, v); chk("R4 data kept", v, 8'h33);
    chk("R10 parity irq", irq_cnt - irq0, 1);

    // R5 frame error discards; receiver rearms
    irq0 = irq_cnt;
    send_rx(8'hC3, 1'b0, 1'b1);
    bus_rd(2'd2, v); chk("R5 frame flag", v, stat_val(0,1,0,0,0));
    bus_rd(2'd0, v); chk("R5 data unchanged", v, 8'h33);
    bus_rd(2'd2, v); chk("R7 frame cleared", v, 8'h00);
    chk("R10 frame irq", irq_cnt - irq0, 1);
    send_rx(8'h11, 1'b0, 1'b0);
    bus_rd(2'd2, v); chk("R5 rearm valid", v, stat_val(0,0,0,0,1));
    bus_rd(2'd0, v); chk("R5 rearm data", v, 8'h11);

    // R6 overrun
    irq0 = irq_cnt;
    send_rx(8'h21, 1'b0, 1'b0);
    send_rx(8'h42, 1'b0, 1'b0);
    bus_rd(2'd2, v); chk("R6 overrun flag", v, stat_val(0,0,1,0,1));
    bus_rd(2'd0, v); chk("R6 first kept", v, 8'h21);
    bus_rd(2'd2, v); chk("R7 overrun cleared", v, 8'h00);
    chk("R10 overrun irq", irq_cnt - irq0, 2);

    // R11 glitch rejection
    irq0 = irq_cnt;
    @(negedge clk) rxd = 1'b0;
    repeat (10) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT * FB) @(negedge clk);
    bus_rd(2'd2, v); chk("R11 glitch status", v, 8'h00);
    chk("R11 glitch irq", irq_cnt - irq0, 0);

    // R8 overwrite of pending char; R2 framing
    irq0 = irq_cnt;
    n0 = dec_n;
    bus_wr(2'd1, 8'hA5);
    repeat (4) @(negedge clk);
    bus_wr(2'd1, 8'h3C);
    bus_rd(2'd2, v); chk("R8 pending bit", v, stat_val(0,0,0,1,0));
    bus_wr(2'd1, 8'h96);
    bus_rd(2'd2, v); chk("R8 still pending", v, stat_val(0,0,0,1,0));
    repeat (3 * BIT * FB) @(negedge clk);
    chk("R8 frames sent", dec_n - n0, 2);
    chk("R2 first data", dec_data[n0], 8'hA5);
    chk("R2 first parity", dec_par[n0], even_par(8'hA5));
    chk("R2 first stop", dec_stop[n0], 1);
    chk("R8 overwritten data", dec_data[n0 + 1], 8'h96);
    bus_rd(2'd2, v); chk("R8 holding empty", v, 8'h00);
    chk("R10 tx irq", irq_cnt - irq0, 2);

    // random traffic in both directions
    for (int k = 0; k < 10; k++) begin
      r = 8'($urandom);
      t = 8'($urandom);
      n0 = dec_n;
      bus_wr(2'd1, t);
      send_rx(r, 1'b0, 1'b0);
      bus_rd(2'd2, v); chk("R3 random status", v, stat_val(0,0,0,0,1));
      bus_rd(2'd0, v); chk("R3 random data", v, r);
      repeat (BIT * FB) @(negedge clk);
      chk("R2 random count", dec_n - n0, 1);
      chk("R2 random data", dec_data[n0], t);
      chk("R2 random parity", dec_par[n0], even_par(t));
      chk("R2 random stop", dec_stop[n0], 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule